// File: doc/BRIEF.md
# Memory Region Decoder with Wait-State Costing

This block sits between a CPU's bus master and the memories of a small system. For each access it takes an address, a transfer size (byte, halfword or word) and a read/write flag. It works out which memory region the access targets and the offset inside that region after alignment and mirroring. It also works out how many bus cycles the access costs. Accesses that hit nothing raise a flag, so that a separate block can supply the floating-bus value on reads or discard the write.

The result is registered. It appears one clock after the access strobe, together with a single-cycle done pulse. The outputs hold their values until the next strobe. The cost table is indexed by address bits [27:24] and by whether the transfer is a word. Each region has its own mirror mask, and both the masks and the costs are parameters.

Top module: `mem_region_decoder`

## Requirements
- R1: Address bits [27:24] pick the region, and the one-hot select reports it with these bit positions: bit0 boot ROM (code 0), bit1 external work RAM (2), bit2 internal work RAM (3), bit3 I/O (4), bit4 palette (5), bit5 video RAM (6), bit6 object memory (7), bit7 cartridge ROM (8 to D), bit8 save memory (E to F). At most one select bit is set.
- R2: Byte and halfword accesses cost 3 cycles at code 2 and 5 cycles at codes 8 to F. Every other code costs 1 cycle.
- R3: Word accesses cost 6 cycles at code 2, 2 cycles at codes 5 and 6, and 8 cycles at codes 8 to F. Every other code costs 1 cycle.
- R4: When any of address bits [31:28] is set, the out-of-range flag is 1 and the select is zero. A read also raises the open-bus flag and a write raises the write-drop flag. The cycle cost is still taken from bits [27:24].
- R5: The offset is the aligned address ANDed with the region's mask: 0x3FFFF for external work RAM, 0x7FFF for internal work RAM, 0x3FF for palette, object memory and I/O, 0x1FFFF for video RAM, 0x1FFFFFF for cartridge ROM, 0xFFFF for save memory and 0x3FFF for boot ROM. The offset is zero when the select is zero.
- R6: Size encoding is 0 for byte, 1 for halfword, 2 for word, and 3 is treated as word. A word clears address bits [1:0], a halfword clears bit 0, and a byte keeps the full address.
- R7: A byte write to object memory selects nothing and raises only the write-drop flag. Byte reads of object memory decode normally.
- R8: Boot ROM decodes only for addresses below 0x4000. Above that limit in code 0, a read raises open-bus and a write raises write-drop.
- R9: I/O decodes only for 0x0400_0000 to 0x0400_03FF. Other code-4 addresses are treated as unmapped.
- R10: Reset clears every output. A strobe in cycle n gives done=1 and the new results in cycle n+1. Done is 0 in any cycle that follows no strobe, and the results hold.
- R11: Code 1 is unmapped. Reads raise open-bus and writes raise write-drop, the select is zero and the cost is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Byte address of the access |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| acc_write | input | 1 | 1 for write, 0 for read |
| rsp_done | output | 1 | One-cycle pulse marking new results |
| rsp_sel | output | 9 | One-hot region select |
| rsp_offset | output | 32 | Aligned, mirrored offset in the region |
| rsp_cycles | output | 4 | Cycle cost of the access |
| rsp_wr_drop | output | 1 | Write discarded |
| rsp_out_of_range | output | 1 | Address bits [31:28] not zero |
| rsp_open_bus | output | 1 | Read found no backing region |

## Verification
The bench checks the edges of the region windows. It probes the last boot ROM byte against the first address past the limit, the last I/O register against 0x0400_0400, and addresses just above each mirror mask. A decoder with a wrong limit would select a region where it should raise open-bus, and one with a wrong mask would return an offset with stray high bits. It also checks that a byte write to object memory is dropped while a byte read there still decodes; a design that filtered on size alone would break one of the two. Out-of-range addresses in the top nibble are checked to still charge the cost of bits [27:24] and to split reads from writes. Size code 3 must align as a word.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WALT = 2'd3
   } acc_size_e;

   localparam int NUM_SLOTS  = 9;
   localparam int SLOT_BOOT  = 0;
   localparam int SLOT_EWRAM = 1;
   localparam int SLOT_IWRAM = 2;
   localparam int SLOT_IO    = 3;
   localparam int SLOT_PAL   = 4;
   localparam int SLOT_VRAM  = 5;
   localparam int SLOT_OAM   = 6;
   localparam int SLOT_CART  = 7;
   localparam int SLOT_SAVE  = 8;

   localparam int NUM_CODES  = 16;
endpackage

// File: rtl/memdec_region_sel.sv
module memdec_region_sel
   import memdec_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BOOT_BYTES = 16384,
   parameter int IO_SPAN    = 1024
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [1:0]           size,
   input  logic                 write,
   output logic [NUM_SLOTS-1:0] sel,
   output logic                 out_of_range
);
   localparam logic [23:0] BOOT_LIM = 24'(BOOT_BYTES);
   localparam logic [23:0] IO_LIM   = 24'(IO_SPAN);

   logic [3:0]           code;
   logic [NUM_SLOTS-1:0] raw_sel;
   logic                 byte_acc;

   assign code         = addr[27:24];
   assign out_of_range = |addr[ADDR_W-1:28];
   assign byte_acc     = (size == SZ_BYTE);

   always_comb begin
      raw_sel = '0;
      unique case (code)
         4'h0: raw_sel[SLOT_BOOT]  = (addr[23:0] < BOOT_LIM);
         4'h2: raw_sel[SLOT_EWRAM] = 1'b1;
         4'h3: raw_sel[SLOT_IWRAM] = 1'b1;
         4'h4: raw_sel[SLOT_IO]    = (addr[23:0] < IO_LIM);
         4'h5: raw_sel[SLOT_PAL]   = 1'b1;
         4'h6: raw_sel[SLOT_VRAM]  = 1'b1;
         4'h7: raw_sel[SLOT_OAM]   = !(write && byte_acc);
         4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD:
               raw_sel[SLOT_CART]  = 1'b1;
         4'hE, 4'hF:
               raw_sel[SLOT_SAVE]  = 1'b1;
         default: raw_sel = '0;
      endcase
   end

   assign sel = out_of_range ? '0 : raw_sel;
endmodule

// File: rtl/memdec_offset_map.sv
module memdec_offset_map
   import memdec_pkg::*;
#(
   parameter int                ADDR_W     = 32,
   parameter int                BOOT_BYTES = 16384,
   parameter int                IO_SPAN    = 1024,
   parameter logic [ADDR_W-1:0] EWRAM_MASK = 'h3FFFF,
   parameter logic [ADDR_W-1:0] IWRAM_MASK = 'h7FFF,
   parameter logic [ADDR_W-1:0] PAL_MASK   = 'h3FF,
   parameter logic [ADDR_W-1:0] VRAM_MASK  = 'h1FFFF,
   parameter logic [ADDR_W-1:0] OAM_MASK   = 'h3FF,
   parameter logic [ADDR_W-1:0] CART_MASK  = 'h1FFFFFF,
   parameter logic [ADDR_W-1:0] SAVE_MASK  = 'hFFFF
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [1:0]           size,
   input  logic [NUM_SLOTS-1:0] sel,
   output logic [ADDR_W-1:0]    offset
);
   localparam logic [ADDR_W-1:0] MASK_TAB [NUM_SLOTS] = '{
      ADDR_W'(BOOT_BYTES - 1), EWRAM_MASK, IWRAM_MASK, ADDR_W'(IO_SPAN - 1),
      PAL_MASK, VRAM_MASK, OAM_MASK, CART_MASK, SAVE_MASK
   };

   logic [ADDR_W-1:0] aligned;
   logic [ADDR_W-1:0] masked [NUM_SLOTS];

   always_comb begin
      aligned = addr;
      unique case (size)
         SZ_BYTE: aligned = addr;
         SZ_HALF: aligned[0] = 1'b0;
         default: aligned[1:0] = 2'b00;
      endcase
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign masked[s] = sel[s] ? (aligned & MASK_TAB[s]) : '0;
   end

   always_comb begin
      offset = '0;
      for (int s = 0; s < NUM_SLOTS; s++) offset = offset | masked[s];
   end
endmodule

// File: rtl/memdec_cost_lut.sv
module memdec_cost_lut
   import memdec_pkg::*;
#(
   parameter int COST_W      = 4,
   parameter int COST_BASE   = 1,
   parameter int COST_EW_N   = 3,
   parameter int COST_EXT_N  = 5,
   parameter int COST_EW_W   = 6,
   parameter int COST_DISP_W = 2,
   parameter int COST_EXT_W  = 8
) (
   input  logic [3:0]        code,
   input  logic              wide,
   output logic [COST_W-1:0] cost
);
   logic [COST_W-1:0] narrow_tab [NUM_CODES];
   logic [COST_W-1:0] wide_tab   [NUM_CODES];

   for (genvar n = 0; n < NUM_CODES; n++) begin : g_code
      localparam int NARROW_C = (n == 2) ? COST_EW_N :
                                (n >= 8) ? COST_EXT_N : COST_BASE;
      localparam int WIDE_C   = (n == 2) ? COST_EW_W :
                                (n == 5 || n == 6) ? COST_DISP_W :
                                (n >= 8) ? COST_EXT_W : COST_BASE;
      assign narrow_tab[n] = COST_W'(NARROW_C);
      assign wide_tab[n]   = COST_W'(WIDE_C);
   end

   assign cost = wide ? wide_tab[code] : narrow_tab[code];
endmodule

// File: rtl/mem_region_decoder.sv
module mem_region_decoder
   import memdec_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                COST_W      = 4,
   parameter int                BOOT_BYTES  = 16384,
   parameter int                IO_SPAN     = 1024,
   parameter logic [ADDR_W-1:0] EWRAM_MASK  = 'h3FFFF,
   parameter logic [ADDR_W-1:0] IWRAM_MASK  = 'h7FFF,
   parameter logic [ADDR_W-1:0] PAL_MASK    = 'h3FF,
   parameter logic [ADDR_W-1:0] VRAM_MASK   = 'h1FFFF,
   parameter logic [ADDR_W-1:0] OAM_MASK    = 'h3FF,
   parameter logic [ADDR_W-1:0] CART_MASK   = 'h1FFFFFF,
   parameter logic [ADDR_W-1:0] SAVE_MASK   = 'hFFFF,
   parameter int                COST_BASE   = 1,
   parameter int                COST_EW_N   = 3,
   parameter int                COST_EXT_N  = 5,
   parameter int                COST_EW_W   = 6,
   parameter int                COST_DISP_W = 2,
   parameter int                COST_EXT_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic [1:0]           acc_size,
   input  logic                 acc_write,
   output logic                 rsp_done,
   output logic [NUM_SLOTS-1:0] rsp_sel,
   output logic [ADDR_W-1:0]    rsp_offset,
   output logic [COST_W-1:0]    rsp_cycles,
   output logic                 rsp_wr_drop,
   output logic                 rsp_out_of_range,
   output logic                 rsp_open_bus
);
   localparam int MAX_COST = (COST_EXT_W > COST_EW_W) ? COST_EXT_W : COST_EW_W;

   if (ADDR_W < 29) begin : g_bad_addr
      $error("ADDR_W must be at least 29");
   end
   if ((1 << COST_W) <= MAX_COST) begin : g_bad_cost
      $error("COST_W too narrow for the largest cost");
   end
   if ((BOOT_BYTES & (BOOT_BYTES - 1)) != 0 || BOOT_BYTES > (1 << 24)) begin : g_bad_boot
      $error("BOOT_BYTES must be a power of two within one region");
   end
   if ((IO_SPAN & (IO_SPAN - 1)) != 0 || IO_SPAN > (1 << 24)) begin : g_bad_io
      $error("IO_SPAN must be a power of two within one region");
   end

   logic [NUM_SLOTS-1:0] nx_sel;
   logic [ADDR_W-1:0]    nx_offset;
   logic [COST_W-1:0]    nx_cost;
   logic                 nx_oor;
   logic                 wide;

   assign wide = acc_size[1];

   memdec_region_sel #(
      .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .IO_SPAN(IO_SPAN)
   ) u_sel (
      .addr(acc_addr), .size(acc_size), .write(acc_write),
      .sel(nx_sel), .out_of_range(nx_oor)
   );

   memdec_offset_map #(
      .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .IO_SPAN(IO_SPAN),
      .EWRAM_MASK(EWRAM_MASK), .IWRAM_MASK(IWRAM_MASK), .PAL_MASK(PAL_MASK),
      .VRAM_MASK(VRAM_MASK), .OAM_MASK(OAM_MASK), .CART_MASK(CART_MASK),
      .SAVE_MASK(SAVE_MASK)
   ) u_off (
      .addr(acc_addr), .size(acc_size), .sel(nx_sel), .offset(nx_offset)
   );

   memdec_cost_lut #(
      .COST_W(COST_W), .COST_BASE(COST_BASE), .COST_EW_N(COST_EW_N),
      .COST_EXT_N(COST_EXT_N), .COST_EW_W(COST_EW_W),
      .COST_DISP_W(COST_DISP_W), .COST_EXT_W(COST_EXT_W)
   ) u_cost (
      .code(acc_addr[27:24]), .wide(wide), .cost(nx_cost)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_done         <= 1'b0;
         rsp_sel          <= '0;
         rsp_offset       <= '0;
         rsp_cycles       <= '0;
         rsp_wr_drop      <= 1'b0;
         rsp_out_of_range <= 1'b0;
         rsp_open_bus     <= 1'b0;
      end else begin
         rsp_done <= acc_valid;
         if (acc_valid) begin
            rsp_sel          <= nx_sel;
            rsp_offset       <= nx_offset;
            rsp_cycles       <= nx_cost;
            rsp_wr_drop      <= acc_write && (nx_sel == '0);
            rsp_out_of_range <= nx_oor;
            rsp_open_bus     <= !acc_write && (nx_sel == '0);
         end
      end
   end
endmodule

// File: rtl/memdec_checker.sv
module memdec_checker
   import memdec_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int COST_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_valid,
   input logic [ADDR_W-1:0]    acc_addr,
   input logic [1:0]           acc_size,
   input logic                 acc_write,
   input logic                 rsp_done,
   input logic [NUM_SLOTS-1:0] rsp_sel,
   input logic [ADDR_W-1:0]    rsp_offset,
   input logic [COST_W-1:0]    rsp_cycles,
   input logic                 rsp_wr_drop,
   input logic                 rsp_out_of_range,
   input logic                 rsp_open_bus
);
   assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_done);

   assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!rsp_done && $stable(rsp_sel) && $stable(rsp_offset)));

   assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_sel));

   assert_oor_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && |acc_addr[ADDR_W-1:28]) |=> (rsp_out_of_range && rsp_sel == '0));

   assert_oam_byte_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_size == SZ_BYTE && acc_addr[ADDR_W-1:24] == 'h07)
      |=> (rsp_wr_drop && rsp_sel == '0 && !rsp_open_bus));

   assert_unmapped_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && (rsp_open_bus || rsp_wr_drop)) |-> (rsp_offset == '0 && rsp_sel == '0));

   assert_cost_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (rsp_cycles != '0));

   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !(rsp_wr_drop && rsp_open_bus));

   assert_word_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size[1]) |=> (rsp_offset[1:0] == 2'b00));
endmodule

bind mem_region_decoder memdec_checker #(.ADDR_W(ADDR_W), .COST_W(COST_W)) u_chk (.*);

// File: tb/mem_region_decoder_tb.sv
`timescale 1ns/1ps
module mem_region_decoder_tb;
   localparam int NV = 24;
   // {addr, size, write, sel, offset, cycles, wr_drop, out_of_range, open_bus}
   localparam logic [82:0] VEC [NV] = '{
      {32'h0000_0123, 2'd0, 1'b0, 9'h001, 32'h0000_0123, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0000_4000, 2'd2, 1'b0, 9'h000, 32'h0000_0000, 4'd1, 1'b0, 1'b0, 1'b1},
      {32'h0204_0006, 2'd1, 1'b0, 9'h002, 32'h0000_0006, 4'd3, 1'b0, 1'b0, 1'b0},
      {32'h0200_1237, 2'd2, 1'b0, 9'h002, 32'h0000_1234, 4'd6, 1'b0, 1'b0, 1'b0},
      {32'h0300_8011, 2'd0, 1'b1, 9'h004, 32'h0000_0011, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0400_03FE, 2'd1, 1'b0, 9'h008, 32'h0000_03FE, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0400_0400, 2'd2, 1'b0, 9'h000, 32'h0000_0000, 4'd1, 1'b0, 1'b0, 1'b1},
      {32'h0500_0D06, 2'd2, 1'b1, 9'h010, 32'h0000_0104, 4'd2, 1'b0, 1'b0, 1'b0},
      {32'h0602_0003, 2'd1, 1'b0, 9'h020, 32'h0000_0002, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0600_0010, 2'd2, 1'b0, 9'h020, 32'h0000_0010, 4'd2, 1'b0, 1'b0, 1'b0},
      {32'h0700_0405, 2'd1, 1'b1, 9'h040, 32'h0000_0004, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0700_0010, 2'd0, 1'b1, 9'h000, 32'h0000_0000, 4'd1, 1'b1, 1'b0, 1'b0},
      {32'h0700_0011, 2'd0, 1'b0, 9'h040, 32'h0000_0011, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0A12_3456, 2'd2, 1'b0, 9'h080, 32'h0012_3454, 4'd8, 1'b0, 1'b0, 1'b0},
      {32'h0D00_0001, 2'd1, 1'b0, 9'h080, 32'h0100_0000, 4'd5, 1'b0, 1'b0, 1'b0},
      {32'h0E00_8001, 2'd0, 1'b1, 9'h100, 32'h0000_8001, 4'd5, 1'b0, 1'b0, 1'b0},
      {32'h0F01_0002, 2'd2, 1'b0, 9'h100, 32'h0000_0000, 4'd8, 1'b0, 1'b0, 1'b0},
      {32'h0100_0000, 2'd1, 1'b0, 9'h000, 32'h0000_0000, 4'd1, 1'b0, 1'b0, 1'b1},
      {32'h0100_0004, 2'd2, 1'b1, 9'h000, 32'h0000_0000, 4'd1, 1'b1, 1'b0, 1'b0},
      {32'h1200_0000, 2'd2, 1'b0, 9'h000, 32'h0000_0000, 4'd6, 1'b0, 1'b1, 1'b1},
      {32'hF800_0000, 2'd1, 1'b1, 9'h000, 32'h0000_0000, 4'd5, 1'b1, 1'b1, 1'b0},
      {32'h0000_3FFF, 2'd1, 1'b1, 9'h001, 32'h0000_3FFE, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0400_0000, 2'd0, 1'b1, 9'h008, 32'h0000_0000, 4'd1, 1'b0, 1'b0, 1'b0},
      {32'h0200_0003, 2'd3, 1'b0, 9'h002, 32'h0000_0000, 4'd6, 1'b0, 1'b0, 1'b0}
   };
   localparam string TAG [NV] = '{
      "R1 R8", "R8", "R2 R5", "R3 R6", "R5", "R9", "R9", "R3 R5", "R5 R6", "R3",
      "R1 R6", "R7", "R7", "R3 R5", "R2 R5", "R2 R5", "R3 R5", "R11", "R11", "R4",
      "R4", "R8 R6", "R9 R1", "R6 R3"
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_write = 1'b0;
   logic        rsp_done;
   logic [8:0]  rsp_sel;
   logic [31:0] rsp_offset;
   logic [3:0]  rsp_cycles;
   logic        rsp_wr_drop;
   logic        rsp_out_of_range;
   logic        rsp_open_bus;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   mem_region_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_size(acc_size), .acc_write(acc_write), .rsp_done(rsp_done),
      .rsp_sel(rsp_sel), .rsp_offset(rsp_offset), .rsp_cycles(rsp_cycles),
      .rsp_wr_drop(rsp_wr_drop), .rsp_out_of_range(rsp_out_of_range),
      .rsp_open_bus(rsp_open_bus)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_zero_state(input string req);
      chk(req, "done",   32'(rsp_done), 32'd0);
      chk(req, "sel",    32'(rsp_sel), 32'd0);
      chk(req, "offset", rsp_offset, 32'd0);
      chk(req, "cycles", 32'(rsp_cycles), 32'd0);
      chk(req, "flags",  32'({rsp_wr_drop, rsp_out_of_range, rsp_open_bus}), 32'd0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk_zero_state("R10 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "idle done", 32'(rsp_done), 32'd0);

      // vector table, back-to-back strobes
      for (int i = 0; i < NV; i++) begin
         acc_valid = 1'b1;
         acc_addr  = VEC[i][82:51];
         acc_size  = VEC[i][50:49];
         acc_write = VEC[i][48];
         @(negedge clk);
         chk(TAG[i], "done",   32'(rsp_done), 32'd1);
         chk(TAG[i], "sel",    32'(rsp_sel), 32'(VEC[i][47:39]));
         chk(TAG[i], "offset", rsp_offset, VEC[i][38:7]);
         chk(TAG[i], "cycles", 32'(rsp_cycles), 32'(VEC[i][6:3]));
         chk(TAG[i], "wr_drop", 32'(rsp_wr_drop), 32'(VEC[i][2]));
         chk(TAG[i], "out_of_range", 32'(rsp_out_of_range), 32'(VEC[i][1]));
         chk(TAG[i], "open_bus", 32'(rsp_open_bus), 32'(VEC[i][0]));
      end

      // R10: no strobe -> done low, results hold from the last vector
      acc_valid = 1'b0;
      acc_addr  = 32'h0700_0000;
      acc_size  = 2'd0;
      acc_write = 1'b1;
      @(negedge clk);
      chk("R10 hold", "done",   32'(rsp_done), 32'd0);
      chk("R10 hold", "sel",    32'(rsp_sel), 32'h002);
      chk("R10 hold", "cycles", 32'(rsp_cycles), 32'd6);

      // R7: byte write then byte read of same object-memory address
      acc_valid = 1'b1;
      @(negedge clk);
      chk("R7 wr", "sel", 32'(rsp_sel), 32'd0);
      chk("R7 wr", "wr_drop", 32'(rsp_wr_drop), 32'd1);
      acc_write = 1'b0;
      @(negedge clk);
      chk("R7 rd", "sel", 32'(rsp_sel), 32'h040);
      chk("R7 rd", "open_bus", 32'(rsp_open_bus), 32'd0);

      // R4: top nibble set on a read of boot region code, cost charged from bits 27:24
      acc_addr = 32'h8000_0000;
      acc_size = 2'd2;
      @(negedge clk);
      chk("R4 top", "sel", 32'(rsp_sel), 32'd0);
      chk("R4 top", "flags", 32'({rsp_wr_drop, rsp_out_of_range, rsp_open_bus}), 32'b011);
      chk("R4 top", "cycles", 32'(rsp_cycles), 32'd1);

      // R10: reset after activity clears outputs
      acc_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk_zero_state("R10 rereset");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule